// File: doc/BRIEF.md
# Synchronizable Triangle Carrier Generator

This block produces the triangular carrier that a pulse width modulator compares its references against. A local up-down counter climbs from zero to a programmed peak and falls back to zero, so one full climb and fall lasts twice the peak in clock cycles. To get a switching frequency f_sw from a clock f_clk, the peak is set to f_clk / (2 * f_sw). A helper function in the package computes this value at elaboration time. At run time the peak arrives as an input.

Several copies of the block can share one carrier. Every copy drives its active carrier value on an output. A follower sets its source select and takes the leader's output on its external carrier input. All followers then run locked to the leader's counter. Each copy marks the top and the bottom of the carrier it outputs with a one-cycle pulse. These pulses can start sampling logic or raise interrupts.

The output carrier is registered, so it trails the selected source by one clock. The two extreme pulses are aligned with the registered value.

Top module: `tcar_sync_carrier`

## Requirements
- R1: In the first cycle after synchronous reset is released, `carrier_o` is 0 and `at_max_o` is low. `at_min_o` is low unless the selected source is already above 0 in that cycle.
- R2: With the local source, the counter starts at 0 and steps by exactly 1 each cycle up to the peak P, then steps down to 0, and repeats with period 2P. Neither 0 nor P is held for two consecutive cycles.
- R3: `carrier_o` shows the selected source value of the previous cycle.
- R4: `at_max_o` is high exactly in the cycles where `carrier_o` is strictly above both its previous value and the current source value. `at_min_o` is high exactly where `carrier_o` is no greater than its previous value and strictly below the current source value. Before reset the previous value counts as 0. With the local source this gives one pulse at each top and one at each bottom.
- R5: A new peak value is taken only in a cycle where the local counter is 0. A ramp that is under way always finishes with the peak it started with.
- R6: A peak input of 0 is treated as a peak of 1.
- R7: `use_ext_i` = 0 selects the local counter and ignores `ext_carrier_i`. `use_ext_i` = 1 selects `ext_carrier_i`.
- R8: While the selected source holds a constant value, neither extreme flag is raised.
- R9: The counter is 20 bits wide. At a 100 MHz clock, the peak helper returns 500000 for 100 Hz and 500 for 100 kHz, and both values fit the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| peak_i | input | 20 | Programmed carrier peak; 0 acts as 1 |
| use_ext_i | input | 1 | Source select: 0 local counter, 1 external input |
| ext_carrier_i | input | 20 | Carrier value from a leading instance |
| carrier_o | output | 20 | Registered active carrier value |
| at_max_o | output | 1 | One-cycle pulse at a carrier top |
| at_min_o | output | 1 | One-cycle pulse at a carrier bottom |

## Verification
The counter assertions assume that the peak input is either constant or changes only in ways that the latch at zero absorbs. They also assume that the local counter keeps running whichever source is selected. The stimulus keeps the peak within the counter's width and changes it at arbitrary points, both mid-ramp and mid-fall.

The flag assertions require nothing of the external input. For that input the bench uses triangles, flat stretches and offset ramps. It switches the source select only while reset is held, so the one-cycle delay of the output can be predicted cycle by cycle.

// File: rtl/tcar_pkg.sv
package tcar_pkg;

    localparam int unsigned CNT_W = 20;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    // State of the local up-down counter.
    typedef struct packed {
        cnt_t      value;
        ramp_dir_e dir;
    } ramp_t;

    // Last registered carrier sample and whether it was reached by a rise.
    typedef struct packed {
        cnt_t value;
        logic rising;
    } trace_t;

    // A zero peak would never be reached on an up ramp; one is the floor.
    function automatic cnt_t floor_peak(cnt_t p);
        return (p == '0) ? cnt_t'(1) : p;
    endfunction

    // Half-period length in clock cycles for a given switching frequency.
    function automatic int unsigned peak_count(int unsigned f_clk, int unsigned f_sw);
        return f_clk / (2 * f_sw);
    endfunction

endpackage

// File: rtl/tcar_ramp.sv
module tcar_ramp
    import tcar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t peak_i,
    output cnt_t count_o
);

    ramp_t st_q, st_d;
    cnt_t  peak_q;
    cnt_t  pk_use;
    logic  live_q;

    // A fresh peak is accepted only while the count sits at zero.
    always_comb begin
        pk_use = (st_q.value == '0) ? floor_peak(peak_i) : peak_q;
        st_d   = st_q;
        if (st_q.dir == RAMP_UP) begin
            st_d.value = st_q.value + cnt_t'(1);
            if (st_d.value == pk_use) st_d.dir = RAMP_DOWN;
        end else begin
            st_d.value = st_q.value - cnt_t'(1);
            if (st_d.value == '0) st_d.dir = RAMP_UP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{value: '0, dir: RAMP_UP};
            peak_q <= floor_peak(peak_i);
            live_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            live_q <= 1'b1;
            if (st_q.value == '0) peak_q <= pk_use;
        end
    end

    assign count_o = st_q.value;

    // R2: each step moves the count by exactly one
    p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (st_q.value == $past(st_q.value) + cnt_t'(1)) ||
                   (st_q.value == $past(st_q.value) - cnt_t'(1)));

    // R2: count never exceeds the peak in force
    p_within_peak_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.value <= peak_q);

    // R2: the bottom is not held for two cycles
    p_min_not_held_r2: assert property (@(posedge clk) disable iff (rst)
        (live_q && st_q.value == '0) |=> st_q.value != '0);

    // R5: the peak stays frozen unless the previous count was zero
    p_peak_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(st_q.value) != '0) |-> $stable(peak_q));

endmodule

// File: rtl/tcar_extrema.sv
module tcar_extrema
    import tcar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t active_i,
    output cnt_t carrier_o,
    output logic at_max_o,
    output logic at_min_o
);

    trace_t tr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q <= '{value: '0, rising: 1'b0};
        end else begin
            tr_q <= '{value: active_i, rising: (active_i > tr_q.value)};
        end
    end

    // The registered sample is an extreme once the next sample reverses the slope.
    assign carrier_o = tr_q.value;
    assign at_max_o  = tr_q.rising  && (active_i < tr_q.value);
    assign at_min_o  = !tr_q.rising && (active_i > tr_q.value);

    // R4: top and bottom pulses never coincide
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({at_max_o, at_min_o}));

    // R4: a top pulse lasts a single cycle
    p_max_single_r4: assert property (@(posedge clk) disable iff (rst)
        at_max_o |=> !at_max_o);

    // R4: a bottom pulse lasts a single cycle
    p_min_single_r4: assert property (@(posedge clk) disable iff (rst)
        at_min_o |=> !at_min_o);

endmodule

// File: rtl/tcar_sync_carrier.sv
module tcar_sync_carrier
    import tcar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] peak_i,
    input  logic             use_ext_i,
    input  logic [CNT_W-1:0] ext_carrier_i,
    output logic [CNT_W-1:0] carrier_o,
    output logic             at_max_o,
    output logic             at_min_o
);

    cnt_t local_count;
    cnt_t active;

    tcar_ramp u_ramp (
        .clk     (clk),
        .rst     (rst),
        .peak_i  (peak_i),
        .count_o (local_count)
    );

    // R7: source select between the local counter and a leader's carrier
    assign active = use_ext_i ? ext_carrier_i : local_count;

    tcar_extrema u_extrema (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .carrier_o (carrier_o),
        .at_max_o  (at_max_o),
        .at_min_o  (at_min_o)
    );

    // R3: the output lags the selected source by one cycle
    p_output_lag_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> carrier_o == $past(active));

endmodule

// File: tb/tb_tcar_sync_carrier.sv
module tb_tcar_sync_carrier;
    import tcar_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] peak_i = '0;
    logic             use_ext_i = 1'b0;
    logic [CNT_W-1:0] ext_carrier_i = '0;
    logic [CNT_W-1:0] carrier_o;
    logic             at_max_o;
    logic             at_min_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Internal-mode model: phase r within a period of 2P, P latched at r == 0.
    int m_r = 0, m_p = 1, m_pr = 0, m_pp = 1;
    bit m_have = 1'b0;

    // External-mode model.
    int e_k = 0;
    int e_car = 0;
    bit e_rise = 1'b0;

    always #4 clk = ~clk;

    tcar_sync_carrier dut (
        .clk           (clk),
        .rst           (rst),
        .peak_i        (peak_i),
        .use_ext_i     (use_ext_i),
        .ext_carrier_i (ext_carrier_i),
        .carrier_o     (carrier_o),
        .at_max_o      (at_max_o),
        .at_min_o      (at_min_o)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clampv(int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int tri_val(int r, int p);
        return (r <= p) ? r : 2 * p - r;
    endfunction

    // External stimulus: triangle, flat stretch, offset triangle.
    function automatic int ext_val(int k);
        if (k < 22) return tri_val(k % 10, 5);
        if (k < 30) return 3;
        return 3 + tri_val((k - 30) % 8, 4);
    endfunction

    task automatic tick_int();
        int cur_peak;
        int ec, emx, emn;
        cur_peak = clampv(int'(peak_i));
        @(posedge clk);
        if (rst) begin
            m_r = 0;
            m_have = 1'b0;
        end else begin
            if (m_r == 0) m_p = cur_peak;
            m_pr = m_r;
            m_pp = m_p;
            m_r = m_r + 1;
            if (m_r == 2 * m_p) m_r = 0;
            m_have = 1'b1;
        end
        #2;
        if (!rst) begin
            ec  = m_have ? tri_val(m_pr, m_pp) : 0;
            emx = (m_have && m_pr == m_pp) ? 1 : 0;
            emn = (m_have && m_pr == 0) ? 1 : 0;
            if (!m_have) begin
                check("R1 carrier after reset", carrier_o, 0);
                check("R1 max after reset", at_max_o, 0);
                check("R1 min after reset", at_min_o, 0);
            end else begin
                check("R2/R3/R5/R7 carrier", carrier_o, ec);
                check("R4 at_max", at_max_o, emx);
                check("R4 at_min", at_min_o, emn);
            end
        end
    endtask

    task automatic reset_int(int pk);
        rst = 1'b1;
        use_ext_i = 1'b0;
        peak_i = CNT_W'(pk);
        tick_int();
        tick_int();
        rst = 1'b0;
    endtask

    task automatic tick_ext();
        int cur_e, nx;
        cur_e = int'(ext_carrier_i);
        @(posedge clk);
        if (rst) begin
            e_k = 0;
            e_car = 0;
            e_rise = 1'b0;
        end else begin
            e_rise = (cur_e > e_car);
            e_car  = cur_e;
            e_k++;
        end
        #1;
        nx = ext_val(e_k);
        ext_carrier_i = CNT_W'(nx);
        #1;
        if (!rst) begin
            check("R3/R7 ext carrier", carrier_o, e_car);
            check("R4 ext at_max", at_max_o, (e_rise && nx < e_car) ? 1 : 0);
            check("R1/R4 ext at_min", at_min_o, (!e_rise && nx > e_car) ? 1 : 0);
            if (e_k >= 24 && e_k <= 29) begin
                check("R8 flat no max", at_max_o, 0);
                check("R8 flat no min", at_min_o, 0);
            end
        end
    endtask

    initial begin
        // R9: helper arithmetic and counter width
        check("R9 peak 100Hz", peak_count(100_000_000, 100), 500000);
        check("R9 peak 100kHz", peak_count(100_000_000, 100_000), 500);
        check("R9 width", (500000 < (1 << CNT_W)) ? 1 : 0, 1);
        check("R9 CNT_W", CNT_W, 20);

        // R2/R4: sweep of small peaks, external input driven with junk (R7)
        for (int p = 1; p <= 8; p++) begin
            reset_int(p);
            ext_carrier_i = CNT_W'(12345 + p);
            for (int c = 0; c < 8 * p + 5; c++) tick_int();
        end

        // R6: zero peak behaves as one
        reset_int(0);
        for (int c = 0; c < 12; c++) tick_int();

        // R5: peak changes mid-rise and mid-fall
        reset_int(6);
        for (int c = 0; c < 70; c++) begin
            tick_int();
            if (c == 3)  peak_i = CNT_W'(3);
            if (c == 20) peak_i = CNT_W'(9);
            if (c == 33) peak_i = CNT_W'(2);
            if (c == 50) peak_i = CNT_W'(0);
        end

        // R9: 100 kHz peak over a full period
        reset_int(peak_count(100_000_000, 100_000));
        for (int c = 0; c < 1005; c++) tick_int();

        // R7/R8: follower mode
        rst = 1'b1;
        use_ext_i = 1'b1;
        peak_i = CNT_W'(4);
        ext_carrier_i = '0;
        tick_ext();
        tick_ext();
        rst = 1'b0;
        #1;
        ext_carrier_i = CNT_W'(ext_val(0));
        #1;
        check("R1 ext carrier after reset", carrier_o, 0);
        check("R1 ext max after reset", at_max_o, 0);
        for (int c = 0; c < 50; c++) tick_ext();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule